// File: doc/BRIEF.md
# Single-Bit Shift and Rotate Unit with Condition Flags

This block is the shift and rotate slice of a processor execution stage. It moves a byte, word or long operand by exactly one bit position. A 2-bit group selector chooses the direction and family: shift left, shift right, rotate left or rotate right. A 4-bit sub-operation nibble then picks the operand size and, within the group, one of its two variants. The unit returns the new operand value together with an updated condition-code byte. In that byte the four arithmetic flags (negative, zero, overflow, carry) are recomputed, and the upper four bits are handed through untouched.

The operand arrives as a full 32-bit register image. For byte and word sizes only the low 8 or 16 bits take part in the operation. The bits above the selected size are returned exactly as they came in, so the result can be written straight back into the register file.

A parameter selects the output timing. With it enabled, the result and flags are registered and appear one clock after the request. With it disabled, the outputs follow the inputs in the same cycle.

Top module: `sru_shift_unit`

## Requirements
- R1: Size decode from the nibble `sub`: when `sub[2:1]` is 00, `sub[0]`=0 selects byte (8 bits) and `sub[0]`=1 selects word (16 bits). Any other value of `sub[2:1]` selects long (32 bits), so nibbles 3, 7 and B are all long.
- R2: Operation decode. `grp` 0 is shift left, 1 is shift right, 2 is rotate left and 3 is rotate right. `sub[3]`=0 picks the first variant of the group: logical shift, or rotate through carry. `sub[3]`=1 picks the second: arithmetic shift, or plain rotate.
- R3: Both left shifts move the operand up one bit and fill bit 0 with 0. C receives the operand's top bit for the size (bit 7, 15 or 31).
- R4: The arithmetic left shift sets V when the result's sign bit differs from the operand's sign bit. The logical left shift always clears V.
- R5: Both right shifts put operand bit 0 into C. The logical right shift fills the top bit with 0 and always returns N=0. The arithmetic right shift keeps the sign bit.
- R6: Rotate through carry (left or right) fills the vacated end with the incoming carry `ccr_in[0]`. C receives the bit that leaves the other end.
- R7: Plain rotate (left or right) fills the vacated end with the bit that leaves the other end. C receives that same bit.
- R8: N is the result bit 7, 15 or 31 for the size. Z is 1 exactly when the low 8, 16 or 32 result bits are all zero.
- R9: V is 0 for every operation other than the arithmetic left shift.
- R10: For byte and word sizes, `result` bits above the size equal the same bits of `opnd`.
- R11: `ccr_out` bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. `ccr_out[7:4]` equals `ccr_in[7:4]`.
- R12: With REG_OUT=1, `result` and `ccr_out` update on the clock edge that samples `in_valid`=1. `out_valid` is high for exactly the following cycle. While `in_valid` is 0 the outputs hold. With REG_OUT=0, the outputs are combinational and `out_valid` equals `in_valid`.
- R13: With REG_OUT=1, a clock edge with `rst_n` low clears `out_valid`, `result` and `ccr_out` to 0, whatever `in_valid` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| grp | input | 2 | Group: shift left, shift right, rotate left, rotate right |
| sub | input | 4 | Sub-operation nibble: size and variant |
| opnd | input | DW (32) | Operand register image |
| ccr_in | input | 8 | Current condition-code byte, carry in bit 0 |
| out_valid | output | 1 | Result strobe |
| result | output | DW (32) | Shifted or rotated value |
| ccr_out | output | 8 | Updated condition-code byte |

## Verification
The bench builds two copies side by side from one stimulus stream. The first uses REG_OUT=1, with a scoreboard that queues expected items and pops them when `out_valid` appears. This copy brings into reach the one-cycle latency, the hold behaviour while idle, and reset overriding a live request. The second uses REG_OUT=0 and is checked in the same cycle the inputs are applied, which exercises the pure combinational path and `out_valid` following `in_valid`. Both copies use the default DW=32, so all three sizes are reachable, along with upper-bit preservation for byte and word and the nibble aliases that decode to long.

// File: rtl/sru_pkg.sv
// Shared types for the shift/rotate unit.
// Assumes: the long size equals the package data width of 32 bits.
package sru_pkg;

    localparam int SRU_DW  = 32;
    localparam int SRU_NSZ = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } sru_size_e;

    // Encoding equals {group, variant bit}.
    typedef enum logic [2:0] {
        K_LSL = 3'd0,
        K_ASL = 3'd1,
        K_LSR = 3'd2,
        K_ASR = 3'd3,
        K_RCL = 3'd4,
        K_ROL = 3'd5,
        K_RCR = 3'd6,
        K_ROR = 3'd7
    } sru_kind_e;

    typedef struct packed {
        sru_size_e size;
        sru_kind_e kind;
    } sru_op_t;

endpackage

// File: rtl/sru_decode.sv
// Turns the group selector and sub-operation nibble into a size and kind.
// Assumes: every nibble value is legal; nibbles outside byte/word decode to long.
module sru_decode
    import sru_pkg::*;
(
    input  logic [1:0] grp,
    input  logic [3:0] sub,
    output sru_op_t    op
);

    // Size from the low three nibble bits, kind from group and variant bit.
    always_comb begin
        if (sub[2:1] != 2'b00) begin
            op.size = SZ_LONG;
        end else if (sub[0]) begin
            op.size = SZ_WORD;
        end else begin
            op.size = SZ_BYTE;
        end
        op.kind = sru_kind_e'({grp, sub[3]});
    end

endmodule

// File: rtl/sru_core.sv
// Data path: one lane per operand size computes the one-bit move and the
// carry-out in parallel; the decoded size picks a lane.
// Assumes: DW is 8 << (NSZ-1); bits above a lane's width pass through.
module sru_core
    import sru_pkg::*;
#(
    parameter int DW  = SRU_DW,
    parameter int NSZ = SRU_NSZ
) (
    input  sru_op_t         op,
    input  logic [DW-1:0]   opnd,
    input  logic            c_in,
    output logic [DW-1:0]   res,
    output logic            c_out
);

    logic [DW-1:0] lane_res [NSZ];
    logic          lane_co  [NSZ];

    for (genvar gi = 0; gi < NSZ; gi++) begin : g_lane
        localparam int W = 8 << gi;
        logic [W-1:0] a;
        logic [W-1:0] r;
        logic         co;

        assign a = opnd[W-1:0];

        // One-bit move of this lane's width for the selected kind.
        always_comb begin
            case (op.kind)
                K_LSL, K_ASL: begin r = {a[W-2:0], 1'b0};   co = a[W-1]; end
                K_LSR:        begin r = {1'b0, a[W-1:1]};   co = a[0];   end
                K_ASR:        begin r = {a[W-1], a[W-1:1]}; co = a[0];   end
                K_RCL:        begin r = {a[W-2:0], c_in};   co = a[W-1]; end
                K_ROL:        begin r = {a[W-2:0], a[W-1]}; co = a[W-1]; end
                K_RCR:        begin r = {c_in, a[W-1:1]};   co = a[0];   end
                default:      begin r = {a[0], a[W-1:1]};   co = a[0];   end
            endcase
        end

        if (W < DW) begin : g_merge
            assign lane_res[gi] = {opnd[DW-1:W], r};
        end else begin : g_full
            assign lane_res[gi] = r;
        end
        assign lane_co[gi] = co;
    end

    // Lane select by decoded size.
    always_comb begin
        case (op.size)
            SZ_BYTE: begin res = lane_res[0]; c_out = lane_co[0]; end
            SZ_WORD: begin res = lane_res[1]; c_out = lane_co[1]; end
            default: begin res = lane_res[NSZ-1]; c_out = lane_co[NSZ-1]; end
        endcase
    end

endmodule

// File: rtl/sru_flags.sv
// Builds the new condition byte: N and Z from the sized result, V only for
// the arithmetic left shift, C from the data path, high nibble passed through.
// Assumes: result bits above the size are not part of any flag.
module sru_flags
    import sru_pkg::*;
#(
    parameter int DW = SRU_DW
) (
    input  sru_op_t        op,
    input  logic [DW-1:0]  opnd,
    input  logic [DW-1:0]  res,
    input  logic           c_out,
    input  logic [7:0]     ccr_in,
    output logic [7:0]     ccr_out
);

    logic top_res;
    logic top_opd;
    logic zero;
    logic n_flag;
    logic v_flag;

    // Sign bits and zero test at the width of the selected size.
    always_comb begin
        case (op.size)
            SZ_BYTE: begin top_res = res[7];    top_opd = opnd[7];    zero = (res[7:0] == '0);  end
            SZ_WORD: begin top_res = res[15];   top_opd = opnd[15];   zero = (res[15:0] == '0); end
            default: begin top_res = res[DW-1]; top_opd = opnd[DW-1]; zero = (res == '0);       end
        endcase
    end

    // Per-kind rules for N and V.
    always_comb begin
        n_flag = (op.kind == K_LSR) ? 1'b0 : top_res;
        v_flag = (op.kind == K_ASL) ? (top_res ^ top_opd) : 1'b0;
    end

    assign ccr_out = {ccr_in[7:4], n_flag, zero, v_flag, c_out};

endmodule

// File: rtl/sru_shift_unit.sv
// Top of the shift/rotate unit: decode, data path, flags, and an optional
// registered output stage chosen by REG_OUT.
// Assumes: synchronous active-low reset; one request per cycle at most.
module sru_shift_unit
    import sru_pkg::*;
#(
    parameter int DW      = SRU_DW,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    grp,
    input  logic [3:0]    sub,
    input  logic [DW-1:0] opnd,
    input  logic [7:0]    ccr_in,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic [7:0]    ccr_out
);

    localparam int NSZ = $clog2(DW / 8) + 1;

    sru_op_t       dec_op;
    logic [DW-1:0] core_res;
    logic          core_co;
    logic [7:0]    ccr_nxt;

    sru_decode u_dec (
        .grp (grp),
        .sub (sub),
        .op  (dec_op)
    );

    sru_core #(.DW(DW), .NSZ(NSZ)) u_core (
        .op    (dec_op),
        .opnd  (opnd),
        .c_in  (ccr_in[0]),
        .res   (core_res),
        .c_out (core_co)
    );

    sru_flags #(.DW(DW)) u_flg (
        .op      (dec_op),
        .opnd    (opnd),
        .res     (core_res),
        .c_out   (core_co),
        .ccr_in  (ccr_in),
        .ccr_out (ccr_nxt)
    );

    if (REG_OUT) begin : g_reg
        // Capture result and flags on a request; reset clears everything.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                result    <= '0;
                ccr_out   <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    result  <= core_res;
                    ccr_out <= ccr_nxt;
                end
            end
        end

        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R12
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(result) && $stable(ccr_out))); // R12
    end else begin : g_comb
        // Pass-through output stage.
        always_comb begin
            out_valid = in_valid;
            result    = core_res;
            ccr_out   = ccr_nxt;
        end
    end

    AST_LSR_NEG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_op.kind == K_LSR) |-> !ccr_nxt[3]); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_op.kind != K_ASL) |-> !ccr_nxt[1]); // R9
    AST_ROL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_op.kind == K_ROL) |-> (core_res[0] == ccr_nxt[0])); // R7
    AST_RCL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_op.kind == K_RCL) |-> (core_res[0] == ccr_in[0])); // R6
    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_op.size == SZ_BYTE) |-> (core_res[DW-1:8] == opnd[DW-1:8])); // R10

endmodule

// File: tb/sim_sru_shift_unit.sv
module sim_sru_shift_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  grp = '0;
    logic [3:0]  sub = '0;
    logic [31:0] opnd = '0;
    logic [7:0]  ccr_in = '0;

    logic        ov0, ov1;
    logic [31:0] res0, res1;
    logic [7:0]  ccr0, ccr1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic [7:0]  ccr;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    logic [31:0] last_res;
    logic [7:0]  last_ccr;

    always #5 clk = ~clk;

    sru_shift_unit #(.DW(32), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .grp(grp), .sub(sub),
        .opnd(opnd), .ccr_in(ccr_in), .out_valid(ov0), .result(res0), .ccr_out(ccr0)
    );

    sru_shift_unit #(.DW(32), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .grp(grp), .sub(sub),
        .opnd(opnd), .ccr_in(ccr_in), .out_valid(ov1), .result(res1), .ccr_out(ccr1)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [1:0] g, input logic [3:0] s,
                                   input logic [31:0] a, input logic [7:0] cc);
        exp_t e;
        int w;
        logic [31:0] mask, m, r;
        logic co, n, z, v;
        w = (s[2:1] != 2'b00) ? 32 : (s[0] ? 16 : 8);        // R1
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        m = a & mask;
        case (g)                                               // R2
            2'd0: begin r = m << 1; co = a[w-1]; end
            2'd1: begin r = m >> 1; if (s[3]) r[w-1] = a[w-1]; co = a[0]; end
            2'd2: begin r = m << 1; r[0] = s[3] ? a[w-1] : cc[0]; co = a[w-1]; end
            default: begin r = m >> 1; r[w-1] = s[3] ? a[0] : cc[0]; co = a[0]; end
        endcase
        r = r & mask;
        n = r[w-1];
        z = (r == 0);
        v = (g == 2'd0 && s[3]) ? (r[w-1] ^ a[w-1]) : 1'b0;
        e.res = r | (a & ~mask);
        e.ccr = {cc[7:4], n, z, v, co};
        e.tag = "";
        return e;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Driver: apply one request, queue its expectation, check the combinational copy.
    task automatic drive(input string tag, input logic [1:0] g, input logic [3:0] s,
                         input logic [31:0] a, input logic [7:0] cc);
        exp_t e;
        @(negedge clk);
        grp = g; sub = s; opnd = a; ccr_in = cc; in_valid = 1'b1;
        e = model(g, s, a, cc);
        e.tag = tag;
        sb_q.push_back(e);
        last_res = e.res;
        last_ccr = e.ccr;
        #1;
        check({tag, " R12 comb"}, {23'd0, ov1, res1, ccr1}, {23'd0, 1'b1, e.res, e.ccr});
    endtask

    // Monitor: pop and compare as registered results appear.
    always @(negedge clk) begin
        if (rst_n && ov0) begin
            if (sb_q.size() == 0) begin
                check("R12 unexpected out_valid", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, {24'd0, res0, ccr0}, {24'd0, e.res, e.ccr});
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R13: reset dominates a live request.
        in_valid = 1'b1; grp = 2'd3; sub = 4'hB; opnd = 32'hFFFF_FFFF; ccr_in = 8'hFF;
        repeat (3) @(negedge clk);
        check("R13 reset state", {23'd0, ov0, res0, ccr0}, 64'd0);
        in_valid = 1'b0;
        #1;
        check("R12 comb idle valid", {63'd0, ov1}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        drive("R3 lsl byte",            2'd0, 4'h0, 32'h1234_56C1, 8'h00);
        drive("R4 asl byte overflow",   2'd0, 4'h8, 32'h0000_0040, 8'h00);
        drive("R4 lsl byte clears V",   2'd0, 4'h0, 32'h0000_0040, 8'h02);
        drive("R4 asl word no change",  2'd0, 4'h9, 32'h0000_C000, 8'h00);
        drive("R5 lsr long",            2'd1, 4'h3, 32'h8000_0001, 8'h08);
        drive("R5 asr word",            2'd1, 4'h9, 32'hABCD_8002, 8'h00);
        drive("R6 rcl byte carry in",   2'd2, 4'h0, 32'h0000_0080, 8'h01);
        drive("R6 rcr word carry in",   2'd3, 4'h1, 32'h0000_0002, 8'h01);
        drive("R7 rol word",            2'd2, 4'h9, 32'h5555_8000, 8'h00);
        drive("R7 ror long",            2'd3, 4'hB, 32'h0000_0001, 8'h00);
        drive("R8 zero in low word",    2'd0, 4'h1, 32'h0001_8000, 8'h00);
        drive("R8 byte N from bit7",    2'd1, 4'h8, 32'h0000_0080, 8'h00);
        drive("R1 nibble 7 is long",    2'd0, 4'h7, 32'h4000_0000, 8'h00);
        drive("R1 nibble 4 is long",    2'd3, 4'h4, 32'h0001_0000, 8'h00);
        drive("R9 rol sign flip no V",  2'd2, 4'h8, 32'h0000_0040, 8'h02);
        drive("R10 byte upper kept",    2'd3, 4'h8, 32'hDEAD_BE01, 8'h00);
        drive("R11 high nibble kept",   2'd1, 4'h0, 32'h0000_0003, 8'hA7);
        drive("R11 old flags replaced", 2'd0, 4'h3, 32'h0000_0001, 8'h5F);

        // R12: idle cycle holds the registered outputs.
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        #1;
        check("R12 hold while idle", {23'd0, ov0, res0, ccr0}, {23'd0, 1'b0, last_res, last_ccr});

        for (int i = 0; i < 400; i++) begin
            logic [1:0] g;
            string t;
            g = 2'($urandom_range(0, 3));
            case (g)
                2'd0: t = "R3 R4 rand shl";
                2'd1: t = "R5 rand shr";
                2'd2: t = "R6 R7 rand rotl";
                default: t = "R6 R7 rand rotr";
            endcase
            drive(t, g, 4'($urandom_range(0, 15)), $urandom, 8'($urandom));
        end

        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 queue drained", 64'(sb_q.size()), 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule